// File: doc/BRIEF.md
# Random/Sequential Step Position Core

This block keeps the current step of a sixteen-step sequencer. A four-bit position counter moves forward by one on a step pulse, on a clock pulse (sequential mode only) or on a tick from an internal fast-advance generator. All of these are single-cycle pulses in one system clock domain. The counter is reset by the system reset, by an external reset pulse, by a reset button pulse or, in gate-reset mode, by a low gate input.

The counter drives an output latch. In sequential mode the latch is transparent and the output follows the counter. In random mode the fast generator runs freely and the counter spins. The latch holds the output and takes a new sample only on a clock pulse. A clock pulse also stops the fast generator for that cycle, so the sample is taken from a stable count. In random mode a 16-bit LFSR adds 0 to 3 cycles to each fast period, so the sampling does not fall into a fixed pattern. In gate-skip mode a low gate enables the fast generator, which moves the sequencer on to later steps. A strobe output marks each cycle in which a new position first appears.

Top module: `stepseq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the output latch clear. After that edge `position` reads 0 and `step_strobe` is low.
- R2: In sequential mode (`random_mode` low), `position` equals the counter. It stays unchanged in any cycle with no advance source and no reset.
- R3: The counter wraps from 15 to 0 on an advance.
- R4: A step pulse, a clock pulse and a fast tick that arrive in the same cycle advance the counter by exactly one.
- R5: `ext_reset` or `button_reset` forces the counter to 0 at that edge, even when advance pulses arrive at the same time.
- R6: With `gate_mode` = 2'b10 (gate reset), a low `gate_in` forces the counter to 0 and overrides a step pulse. A high `gate_in` has no effect.
- R7: With `gate_mode` = 2'b01 (gate skip), the fast generator is enabled while `gate_in` is low. It advances the counter at the first low edge and then once every `fast_div`+1 cycles while the gate stays low. It stops when the gate goes high.
- R8: With `gate_mode` = 2'b00 or 2'b11, `gate_in` has no effect.
- R9: In random mode `position` holds, and `step_strobe` stays low, in every cycle without a clock pulse. Step pulses and fast ticks do not change this.
- R10: In random mode a clock pulse loads the latch with the counter value at that edge. The pulse does not advance the counter and disables the fast generator for that cycle. The new value is visible after the edge.
- R11: `step_strobe` is high for exactly the cycle in which `position` first shows a value different from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| random_mode | input | 1 | 1 = random sampling, 0 = sequential |
| gate_mode | input | 2 | 00/11 gate unused, 01 gate skip, 10 gate reset |
| gate_in | input | 1 | Gate level; the low level is active |
| clock_pulse | input | 1 | Single-cycle clock pulse |
| step_pulse | input | 1 | Single-cycle manual step |
| ext_reset | input | 1 | Single-cycle external reset |
| button_reset | input | 1 | Single-cycle reset button |
| fast_div | input | DIV_W | Fast generator period minus one |
| position | output | 4 | Latched step position, 0 = step 1 |
| step_strobe | output | 1 | High in the cycle a new position appears |

## Verification
On every cycle the assertions check the following:
- The counter rules: reset wins, a merged advance adds exactly one, and with no source the counter holds.
- The latch rules in random mode: the latch holds between clock pulses and loads the counter value on a clock pulse.
- In sequential mode the latch tracks the counter.
- With jitter off and a nonzero divider, the fast generator never ticks on two cycles in a row.

The bench scenarios show behaviour over many cycles:
- the exact tick timing of gate skip across a long low gate;
- the wrap from 15 to 0;
- gate-reset overriding a step, and the ignored gate modes;
- the strobe at the ports;
- a deterministic random-mode sequence, which shows that a clock pulse captures the value without advancing the counter.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int POS_W  = 4;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        GATE_UNUSED  = 2'b00,
        GATE_SKIP    = 2'b01,
        GATE_CLEAR   = 2'b10,
        GATE_UNUSED2 = 2'b11
    } gate_mode_e;

    typedef struct packed {
        logic step;
        logic clock;
        logic fast;
    } adv_req_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/fast_tick_gen.sv
module fast_tick_gen
    import seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             jitter_on,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  reload;
    logic [LFSR_W-1:0] lfsr_q;

    always_comb begin
        reload = {1'b0, div};
        if (jitter_on)
            reload = reload + CNT_W'(lfsr_q[1:0]);
    end

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lfsr_q <= LFSR_SEED;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
            if (jitter_on)
                lfsr_q <= lfsr_next(lfsr_q);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !jitter_on && div != '0) |=> !tick); // R7

endmodule

// File: rtl/position_counter.sv
module position_counter
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  adv_req_t req,
    output pos_t     cnt,
    output pos_t     cnt_next
);
    logic advance;

    assign advance = req.step | req.clock | req.fast;

    always_comb begin
        if (clear)
            cnt_next = '0;
        else if (advance)
            cnt_next = cnt + 1'b1;
        else
            cnt_next = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_next;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0); // R5

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && advance) |=> cnt == pos_t'($past(cnt) + 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && !advance) |=> $stable(cnt)); // R2

endmodule

// File: rtl/output_latch.sv
module output_latch
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic random_mode,
    input  logic capture,
    input  pos_t cnt,
    input  pos_t cnt_next,
    output pos_t position,
    output logic strobe
);
    pos_t held_q;
    pos_t shown_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (!random_mode)
            held_q <= cnt_next;
        else if (capture)
            held_q <= cnt;
    end

    assign position = random_mode ? held_q : cnt;

    always_ff @(posedge clk) begin
        if (rst)
            shown_q <= '0;
        else
            shown_q <= position;
    end

    assign strobe = (position != shown_q);

    AST_RANDOM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (random_mode && !capture) |=> $stable(held_q)); // R9

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (random_mode && capture) |=> held_q == $past(cnt)); // R10

    AST_TRACK: assert property (@(posedge clk) disable iff (rst)
        !random_mode |=> held_q == cnt); // R2

endmodule

// File: rtl/stepseq_core.sv
module stepseq_core
    import seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             random_mode,
    input  logic [1:0]       gate_mode,
    input  logic             gate_in,
    input  logic             clock_pulse,
    input  logic             step_pulse,
    input  logic             ext_reset,
    input  logic             button_reset,
    input  logic [DIV_W-1:0] fast_div,
    output logic [3:0]       position,
    output logic             step_strobe
);
    gate_mode_e gmode;
    logic       gate_low;
    logic       skip_active;
    logic       gate_clear;
    logic       any_clear;
    logic       fast_en;
    logic       fast_tick;
    adv_req_t   req;
    pos_t       cnt;
    pos_t       cnt_next;
    pos_t       pos_int;

    assign gmode       = gate_mode_e'(gate_mode);
    assign gate_low    = !gate_in;
    assign skip_active = (gmode == GATE_SKIP)  && gate_low;
    assign gate_clear  = (gmode == GATE_CLEAR) && gate_low;
    assign any_clear   = ext_reset | button_reset | gate_clear;

    // a clock pulse in random mode halts the fast source for that cycle
    assign fast_en = (random_mode | skip_active) & !(random_mode & clock_pulse);

    assign req.step  = step_pulse;
    assign req.clock = clock_pulse & !random_mode;
    assign req.fast  = fast_tick;

    fast_tick_gen #(.DIV_W(DIV_W)) u_fast (
        .clk       (clk),
        .rst       (rst),
        .en        (fast_en),
        .jitter_on (random_mode),
        .div       (fast_div),
        .tick      (fast_tick)
    );

    position_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (any_clear),
        .req      (req),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    output_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .random_mode (random_mode),
        .capture     (clock_pulse),
        .cnt         (cnt),
        .cnt_next    (cnt_next),
        .position    (pos_int),
        .strobe      (step_strobe)
    );

    assign position = pos_int;

    AST_GATE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((gmode == GATE_CLEAR) && !gate_in && !random_mode) |=> position == 4'd0); // R6

endmodule

// File: tb/stepseq_core_test.sv
module stepseq_core_test;

    localparam int K_NONE  = 0;
    localparam int K_EXACT = 1;
    localparam int K_HOLD  = 2;
    localparam int K_CHG   = 3;

    typedef struct {
        int         kind;
        logic [3:0] pos;
        logic       strb;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rmode = 1'b0;
    logic [1:0] gmode = 2'b00;
    logic       gin = 1'b1;
    logic       ck = 1'b0, st = 1'b0, er = 1'b0, br = 1'b0;
    logic [7:0] fdiv = 8'd0;
    logic [3:0] position;
    logic       step_strobe;

    item_t      q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [3:0] prev_pos = 4'd0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    stepseq_core #(.DIV_W(8)) uut (
        .clk          (clk),
        .rst          (rst),
        .random_mode  (rmode),
        .gate_mode    (gmode),
        .gate_in      (gin),
        .clock_pulse  (ck),
        .step_pulse   (st),
        .ext_reset    (er),
        .button_reset (br),
        .fast_div     (fdiv),
        .position     (position),
        .step_strobe  (step_strobe)
    );

    task automatic drv(input logic s_st, input logic s_ck, input logic s_er,
                       input logic s_br, input int kind, input logic [3:0] p,
                       input logic s, input string tag);
        item_t it;
        @(negedge clk);
        st = s_st; ck = s_ck; er = s_er; br = s_br;
        it.kind = kind; it.pos = p; it.strb = s; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // monitor: compares each cycle's outputs with the queued expectation
    always begin
        item_t it;
        @(posedge clk);
        #5;
        if (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                K_EXACT: begin
                    n_cmp++;
                    if (position !== it.pos || step_strobe !== it.strb) begin
                        n_bad++;
                        $display("FAIL %s: pos=%0d strobe=%0b expected pos=%0d strobe=%0b",
                                 it.tag, position, step_strobe, it.pos, it.strb);
                    end
                end
                K_HOLD: begin
                    n_cmp++;
                    if (position !== prev_pos || step_strobe !== 1'b0) begin
                        n_bad++;
                        $display("FAIL %s: pos=%0d strobe=%0b expected pos=%0d strobe=0",
                                 it.tag, position, step_strobe, prev_pos);
                    end
                end
                K_CHG: begin
                    n_cmp++;
                    if (step_strobe !== (position != prev_pos)) begin
                        n_bad++;
                        $display("FAIL %s: strobe=%0b expected %0b (pos %0d after %0d)",
                                 it.tag, step_strobe, (position != prev_pos), position, prev_pos);
                    end
                end
                default: ;
            endcase
        end
        prev_pos = position;
    end

    initial begin
        // R1 reset state
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R1");
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R1");
        rst = 1'b0;
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R1");

        // R2 / R11 sequential stepping and clocking
        drv(1, 0, 0, 0, K_EXACT, 4'd1, 1'b1, "R11");
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R2");
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R2");
        drv(0, 1, 0, 0, K_EXACT, 4'd2, 1'b1, "R2");

        // R4 simultaneous step and clock
        drv(1, 1, 0, 0, K_EXACT, 4'd3, 1'b1, "R4");
        drv(0, 0, 0, 0, K_EXACT, 4'd3, 1'b0, "R11");

        // R3 wrap
        for (int i = 4; i < 16; i++)
            drv(1, 0, 0, 0, K_EXACT, 4'(i), 1'b1, "R3");
        drv(1, 0, 0, 0, K_EXACT, 4'd0, 1'b1, "R3");
        drv(1, 0, 0, 0, K_EXACT, 4'd1, 1'b1, "R3");

        // R5 external and button reset beat advances
        drv(1, 0, 1, 0, K_EXACT, 4'd0, 1'b1, "R5");
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R5");
        drv(1, 0, 0, 0, K_EXACT, 4'd1, 1'b1, "R5");
        drv(0, 1, 0, 1, K_EXACT, 4'd0, 1'b1, "R5");

        // R6 gate reset mode
        gmode = 2'b10; gin = 1'b1;
        drv(1, 0, 0, 0, K_EXACT, 4'd1, 1'b1, "R6");
        gin = 1'b0;
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b1, "R6");
        drv(1, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R6");
        gin = 1'b1;
        drv(1, 0, 0, 0, K_EXACT, 4'd1, 1'b1, "R6");

        // R8 gate ignored
        gmode = 2'b00; gin = 1'b0;
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R8");
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R8");
        gmode = 2'b11;
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R8");
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R8");

        // R7 gate skip with fast_div = 3
        gmode = 2'b01; gin = 1'b1; fdiv = 8'd3;
        drv(0, 0, 0, 0, K_EXACT, 4'd1, 1'b0, "R7");
        gin = 1'b0;
        for (int i = 0; i < 8; i++)
            drv(0, 0, 0, 0, K_EXACT, (i < 4) ? 4'd2 : 4'd3, (i == 0 || i == 4), "R7");
        gin = 1'b1;
        drv(0, 0, 0, 0, K_EXACT, 4'd3, 1'b0, "R7");
        drv(0, 0, 0, 0, K_EXACT, 4'd3, 1'b0, "R7");

        // R9 / R10 deterministic random sequence with a long fast period
        gmode = 2'b00; fdiv = 8'd200; rmode = 1'b1;
        drv(0, 0, 0, 0, K_EXACT, 4'd3, 1'b0, "R9");   // fast tick: counter 4
        drv(1, 0, 0, 0, K_EXACT, 4'd3, 1'b0, "R9");   // step: counter 5
        drv(0, 1, 0, 0, K_EXACT, 4'd5, 1'b1, "R10");  // capture 5
        drv(0, 1, 0, 0, K_EXACT, 4'd5, 1'b0, "R10");  // clock did not advance
        drv(0, 0, 0, 0, K_EXACT, 4'd5, 1'b0, "R9");   // fast tick: counter 6
        drv(0, 1, 0, 0, K_EXACT, 4'd6, 1'b1, "R10");

        // R9 / R10 free-running fast source
        fdiv = 8'd0;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 5; j++)
                drv((j == 2), 0, 0, 0, K_HOLD, 4'd0, 1'b0, "R9");
            drv(0, 1, 0, 0, K_CHG, 4'd0, 1'b0, "R10");
        end

        // back to sequential, known state via external reset
        rmode = 1'b0;
        drv(0, 0, 1, 0, K_NONE, 4'd0, 1'b0, "R5");
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R5");
        drv(0, 0, 0, 0, K_EXACT, 4'd0, 1'b0, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule